// File: doc/BRIEF.md
# Bidirectional Cascadable Sampling-Strobe Shifter

This block produces the one-hot sampling strobes that a column driver uses to capture its analog channels in groups. A single start pulse enters at one end of a chain of stage positions. A token then walks the chain one position per rising clock edge. Each position opens the sampling switches of a fixed group of channels, with twelve channels per group at the default size. With 26 stages this covers 312 channels.

The `shift_right` input selects the walking direction, and it also selects which end pin takes the start pulse. With `shift_right` high, the right-end pin is the input, the token begins at stage index 0 and walks upward, and the left-end pin carries the pulse out. With `shift_right` low, the roles of the two pins swap and the token begins at the highest index. Each end pin is split into three core-side signals: an input, an output and an output enable. A pad drives the pin only when its enable is set.

The outgoing pulse is high during the cycle in which the final stage is active. A next chip, wired to this pin, captures that pulse on the same edge that retires the token here. Its first stage is therefore active in the very next cycle, and sampling continues across chips without a gap.

The controller is a two-state machine:
- SPS_IDLE: no strobe is active.
- SPS_SHIFT: the token is at a position.

The transitions are:
- idle to shift: a start is seen.
- shift to shift: the token advances, or a new start restarts it.
- shift to idle: the token leaves the last position with no new start.

Top module: `sps_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stage strobe, every channel enable and both pulse outputs from the following cycle on.
- R2: With `shift_right` = 1, a high on `edge_r_in` at a rising edge makes `stage_strobe[0]` the only high strobe in the next cycle. Each following edge moves the strobe from index k to k+1, up to index STAGES-1.
- R3: With `shift_right` = 0, a high on `edge_l_in` at a rising edge makes `stage_strobe[STAGES-1]` the only high strobe in the next cycle. Each following edge moves the strobe from index k to k-1, down to index 0.
- R4: At most one bit of `stage_strobe` is high in any cycle. One edge after the last position of a walk is active, with no new start seen, all strobes are low and stay low until a start is seen.
- R5: The outgoing pulse value is high in exactly the cycles in which the last position of the current walk is active. That position is index STAGES-1 when shifting right and index 0 when shifting left. The pulse appears on `edge_l_out` when `shift_right` = 1 and on `edge_r_out` when `shift_right` = 0, and the other out signal is low.
- R6: `edge_l_oe` equals `shift_right` and `edge_r_oe` equals its inverse. A high on the pin that is in the output role has no effect on the strobes.
- R7: A start seen while a walk is in progress restarts the walk at its first position in the next cycle, whatever the current position. A start held high for several edges keeps the first position active. The aborted walk produces no outgoing pulse.
- R8: `chan_sample[s*GROUP + g]` equals `stage_strobe[s]` for every group member g (0 to GROUP-1) in both directions, so the channel order never depends on the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_right | input | 1 | 1: walk from index 0 upward; 0: walk from the top index downward |
| edge_r_in | input | 1 | Right-end pin, received value (start input when shifting right) |
| edge_r_out | output | 1 | Right-end pin, value to drive (pulse out when shifting left) |
| edge_r_oe | output | 1 | Right-end pin output enable |
| edge_l_in | input | 1 | Left-end pin, received value (start input when shifting left) |
| edge_l_out | output | 1 | Left-end pin, value to drive (pulse out when shifting right) |
| edge_l_oe | output | 1 | Left-end pin output enable |
| stage_strobe | output | STAGES (26) | One-hot sampling strobe per stage |
| chan_sample | output | STAGES*GROUP (312) | Per-channel sampling enable |

## Verification
The bench runs full walks in both directions and checks where each walk begins, every step, and the single-cycle pulse at its end. A design that reversed the index order, or that fired the pulse one cycle early or late, would break the gapless hand-over between chips. The bench restarts walks in the middle and again on the very last position; a design that ignored the restart, or leaked a pulse from the aborted walk, would show two tokens or a stray pulse.

The bench also drives the output-role pin high, to catch a design that listens to both ends. It holds the start high for several edges, applies a reset in the middle of a walk, and compares every channel enable against its stage, to catch a direction-dependent remapping of the channels.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [0:0] {
        SPS_IDLE  = 1'b0,
        SPS_SHIFT = 1'b1
    } sps_state_t;
endpackage

// File: rtl/sps_pin_roles.sv
module sps_pin_roles (
    input  logic clk,
    input  logic rst,
    input  logic shift_right,
    input  logic edge_r_in,
    input  logic edge_l_in,
    input  logic pulse_q,
    output logic start_seen,
    output logic edge_r_out,
    output logic edge_r_oe,
    output logic edge_l_out,
    output logic edge_l_oe
);
    always_comb begin
        start_seen = shift_right ? edge_r_in : edge_l_in;
        edge_l_oe  = shift_right;
        edge_r_oe  = !shift_right;
        edge_l_out = pulse_q & shift_right;
        edge_r_out = pulse_q & !shift_right;
    end

    // R6: exactly one end pin is enabled as a driver at any time
    a_r6_single_driver: assert property (@(posedge clk) disable iff (rst)
        edge_r_oe != edge_l_oe);

    // R5: the pin in the input role never carries the pulse
    a_r5_quiet_input_pin: assert property (@(posedge clk) disable iff (rst)
        !(edge_r_oe == 1'b0 && edge_r_out == 1'b1) && !(edge_l_oe == 1'b0 && edge_l_out == 1'b1));
endmodule

// File: rtl/sps_token_fsm.sv
module sps_token_fsm #(
    parameter int STAGES = 26,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_in,
    output logic          run,
    output logic [PW-1:0] pos,
    output logic          dir_q,
    output logic          pulse_q
);
    import sps_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(STAGES - 1);

    sps_state_t    state_q, state_d;
    logic [PW-1:0] pos_d;
    logic          dir_d;
    logic          pulse_d;

    // next state and position
    always_comb begin
        state_d = state_q;
        pos_d   = pos;
        dir_d   = dir_q;
        if (start) begin
            state_d = SPS_SHIFT;
            pos_d   = '0;
            dir_d   = dir_in;
        end else begin
            unique case (state_q)
                SPS_IDLE: begin
                    state_d = SPS_IDLE;
                    pos_d   = '0;
                end
                SPS_SHIFT: begin
                    if (pos == LAST) begin
                        state_d = SPS_IDLE;
                        pos_d   = '0;
                    end else begin
                        state_d = SPS_SHIFT;
                        pos_d   = pos + 1'b1;
                    end
                end
                default: begin
                    state_d = SPS_IDLE;
                    pos_d   = '0;
                end
            endcase
        end
        pulse_d = (state_d == SPS_SHIFT) && (pos_d == LAST);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPS_IDLE;
            pos     <= '0;
            dir_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            pos     <= pos_d;
            dir_q   <= dir_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_d;
    end

    assign run = (state_q == SPS_SHIFT);

    // R2: a running token advances by one position per edge
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && pos != LAST && !start) |=> (run && pos == $past(pos) + 1'b1));

    // R7: a start always lands on the first position
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (run && pos == '0));

    // R4: the chain idles after the last position
    a_r4_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (run && pos == LAST && !start) |=> !run);

    // R1: reset clears the walk and the pulse
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!run && !pulse_q));
endmodule

// File: rtl/sps_strobe_decode.sv
module sps_strobe_decode #(
    parameter int STAGES = 26,
    parameter int GROUP  = 12,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1,
    localparam int CHANNELS = STAGES * GROUP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PW-1:0]       pos,
    input  logic                dir_q,
    output logic [STAGES-1:0]   stage_strobe,
    output logic [CHANNELS-1:0] chan_sample
);
    genvar s, g;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            localparam logic [PW-1:0] UP_IDX = PW'(s);
            localparam logic [PW-1:0] DN_IDX = PW'(STAGES - 1 - s);
            assign stage_strobe[s] = run && (pos == (dir_q ? UP_IDX : DN_IDX));
            for (g = 0; g < GROUP; g++) begin : g_chan
                assign chan_sample[s*GROUP + g] = stage_strobe[s];
            end
        end
    endgenerate

    // R4: never more than one strobe
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_strobe));

    // R8: the number of open channels is zero or one full group
    a_r8_group_count: assert property (@(posedge clk) disable iff (rst)
        ($countones(chan_sample) == 0) || ($countones(chan_sample) == GROUP));
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter #(
    parameter int STAGES = 26,
    parameter int GROUP  = 12,
    localparam int PW = (STAGES > 1) ? $clog2(STAGES) : 1,
    localparam int CHANNELS = STAGES * GROUP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_right,
    input  logic                edge_r_in,
    output logic                edge_r_out,
    output logic                edge_r_oe,
    input  logic                edge_l_in,
    output logic                edge_l_out,
    output logic                edge_l_oe,
    output logic [STAGES-1:0]   stage_strobe,
    output logic [CHANNELS-1:0] chan_sample
);
    logic          start_seen;
    logic          run;
    logic [PW-1:0] pos;
    logic          dir_q;
    logic          pulse_q;

    sps_pin_roles u_roles (
        .clk        (clk),
        .rst        (rst),
        .shift_right(shift_right),
        .edge_r_in  (edge_r_in),
        .edge_l_in  (edge_l_in),
        .pulse_q    (pulse_q),
        .start_seen (start_seen),
        .edge_r_out (edge_r_out),
        .edge_r_oe  (edge_r_oe),
        .edge_l_out (edge_l_out),
        .edge_l_oe  (edge_l_oe)
    );

    sps_token_fsm #(.STAGES(STAGES)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start_seen),
        .dir_in (shift_right),
        .run    (run),
        .pos    (pos),
        .dir_q  (dir_q),
        .pulse_q(pulse_q)
    );

    sps_strobe_decode #(.STAGES(STAGES), .GROUP(GROUP)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .pos         (pos),
        .dir_q       (dir_q),
        .stage_strobe(stage_strobe),
        .chan_sample (chan_sample)
    );

    // R5: the pulse coincides with the end strobe of the walk's direction
    a_r5_pulse_at_end: assert property (@(posedge clk) disable iff (rst)
        pulse_q == (dir_q ? stage_strobe[STAGES-1] : stage_strobe[0]));
endmodule

// File: tb/sps_shifter_test.sv
module sps_shifter_test;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES = 26;
    localparam int GROUP  = 12;
    localparam int CHANNELS = STAGES * GROUP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_right = 1'b1;
    logic edge_r_in = 1'b0;
    logic edge_l_in = 1'b0;
    logic edge_r_out, edge_r_oe, edge_l_out, edge_l_oe;
    logic [STAGES-1:0]   stage_strobe;
    logic [CHANNELS-1:0] chan_sample;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    // reference model state
    int  m_pos = -1;
    bit  m_dir = 1'b1;
    bit  m_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sps_shifter #(.STAGES(STAGES), .GROUP(GROUP)) uut (
        .clk(clk), .rst(rst), .shift_right(shift_right),
        .edge_r_in(edge_r_in), .edge_r_out(edge_r_out), .edge_r_oe(edge_r_oe),
        .edge_l_in(edge_l_in), .edge_l_out(edge_l_out), .edge_l_oe(edge_l_oe),
        .stage_strobe(stage_strobe), .chan_sample(chan_sample)
    );

    always @(posedge clk) begin
        bit st;
        if (rst) begin
            m_pos = -1; m_dir = 1'b1; m_pulse = 1'b0;
        end else begin
            st = shift_right ? edge_r_in : edge_l_in;
            if (st) begin
                m_pos = 0; m_dir = shift_right;
            end else if (m_pos >= 0) begin
                if (m_pos == STAGES-1) m_pos = -1;
                else m_pos = m_pos + 1;
            end
            m_pulse = (m_pos == STAGES-1);
        end
    end

    task automatic check(input string req, input logic [CHANNELS-1:0] act,
                         input logic [CHANNELS-1:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [STAGES-1:0]   e_str;
            logic [CHANNELS-1:0] e_ch;
            e_str = '0;
            if (m_pos >= 0) e_str[m_dir ? m_pos : STAGES-1-m_pos] = 1'b1;
            for (int s = 0; s < STAGES; s++)
                for (int g = 0; g < GROUP; g++)
                    e_ch[s*GROUP+g] = e_str[s];
            check(tag, CHANNELS'(stage_strobe), CHANNELS'(e_str), "stage_strobe");
            check("R4", CHANNELS'($countones(stage_strobe) <= 1), CHANNELS'(1), "onehot");
            check("R8", chan_sample, e_ch, "chan_sample");
            check("R5", CHANNELS'({edge_l_out, edge_r_out}),
                  CHANNELS'({m_pulse & shift_right, m_pulse & !shift_right}), "pulse l/r");
            check("R6", CHANNELS'({edge_l_oe, edge_r_oe}),
                  CHANNELS'({shift_right, !shift_right}), "oe l/r");
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_pin(input bit right_pin, input int len);
        if (right_pin) edge_r_in = 1'b1; else edge_l_in = 1'b1;
        wait_cycles(len);
        edge_r_in = 1'b0; edge_l_in = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait_cycles(3);
        cmp_on = 1'b1;
        wait_cycles(1);
        rst = 1'b0;
        tag = "R1"; wait_cycles(3);
        // R2 right walk
        tag = "R2"; shift_right = 1'b1; pulse_pin(1'b1, 1); wait_cycles(30);
        // R6 wrong pin in right mode
        tag = "R6"; pulse_pin(1'b0, 1); wait_cycles(5);
        // R3 left walk
        tag = "R3"; shift_right = 1'b0; wait_cycles(1); pulse_pin(1'b0, 1); wait_cycles(30);
        // R6 wrong pin in left mode
        tag = "R6"; pulse_pin(1'b1, 1); wait_cycles(5);
        // R7 mid-walk restart, right
        tag = "R7"; shift_right = 1'b1; wait_cycles(1);
        pulse_pin(1'b1, 1); wait_cycles(10); pulse_pin(1'b1, 1); wait_cycles(30);
        // R7 restart on last position, left
        shift_right = 1'b0; wait_cycles(1);
        pulse_pin(1'b0, 1); wait_cycles(25); pulse_pin(1'b0, 1); wait_cycles(30);
        // R7 held start
        pulse_pin(1'b0, 3); wait_cycles(30);
        // R4 back-to-back walks, right
        tag = "R4"; shift_right = 1'b1; wait_cycles(1);
        pulse_pin(1'b1, 1); wait_cycles(STAGES); pulse_pin(1'b1, 1); wait_cycles(30);
        // R1 reset in mid walk
        tag = "R1"; pulse_pin(1'b1, 1); wait_cycles(5);
        rst = 1'b1; wait_cycles(1); rst = 1'b0; wait_cycles(5);
        // R5 left walk with pulse after reset
        tag = "R5"; shift_right = 1'b0; wait_cycles(1); pulse_pin(1'b0, 1); wait_cycles(30);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule